// File: doc/BRIEF.md
# Modem Control and Status Register Block

This block sits beside a UART core and owns its two modem registers: a control register that drives four general-purpose handshake outputs and a loopback switch, and a status register that reports four handshake inputs from the far end of the line. Each input is passed through a synchroniser. The block compares each input with the value it last stored and records every change in a sticky change flag. The interrupt unit watches one summary flag that is high while any change flag is set.

Software reaches both registers through a byte-wide read and write port. The control register sits at offset 4 and the status register at offset 6. A status read returns the current line levels in the upper nibble and the change flags in the lower nibble. A status read also clears the change flags, except when a line change lands on that same edge. In loopback mode a status read shows the block's own control outputs wired back onto the input positions, and the external pins are ignored.

Top module: `modem_ctl_status`

## Requirements
- R1: After reset, the control register reads 0x08 (only bit 3 set), the status register reads 0xB0, the outputs are dtr=0, rts=0, aux1=0 and aux2=1, and delta_pending is low.
- R2: A write at offset 4 stores data bits 4:0 and discards bits 7:5. Bit 0 drives dtr, bit 1 rts, bit 2 aux1, bit 3 aux2 and bit 4 selects loopback. The outputs follow on the clock edge that completes the write, and a read at offset 4 returns {3'b000, stored bits}.
- R3: In normal mode, status bits 7:4 show the line levels: bit 7 carrier (line_dcd), bit 6 ring (line_ri), bit 5 data-set-ready (line_dsr), bit 4 clear-to-send (line_cts). A pin change is visible three clock edges after it is applied.
- R4: Status bits 3, 1 and 0 are change flags for carrier, data-set-ready and clear-to-send. Each is set when its line level changes in either direction and stays set until a status read clears it, even if the line returns to its earlier level.
- R5: Status bit 2 is set only when the ring line goes from 1 to 0. A rising ring line leaves it clear.
- R6: A normal-mode status read returns the flags as they were before the read and clears all four flags on the edge that completes the read.
- R7: A line change that is taken in on the same edge as a clearing status read leaves its flag set after the read.
- R8: In loopback, a status read returns {aux2, aux1, dtr, rts, 4'b0000} and does not depend on the pins. The read does not clear the change flags.
- R9: delta_pending is high exactly when at least one of the four change flags is set.
- R10: Writes at offset 6 have no effect. Reads at any offset other than 4 or 6 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle; the side effects of a read take place on its edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| line_cts | input | 1 | Clear-to-send input, asynchronous, high = asserted |
| line_dsr | input | 1 | Data-set-ready input, asynchronous |
| line_dcd | input | 1 | Carrier-detect input, asynchronous |
| line_ri | input | 1 | Ring input, asynchronous |
| out_dtr | output | 1 | Terminal-ready output |
| out_rts | output | 1 | Request-to-send output |
| out_aux1 | output | 1 | General-purpose output 1 |
| out_aux2 | output | 1 | General-purpose output 2 |
| delta_pending | output | 1 | High while any change flag is set |

## Verification
The bench steps through every ordered pair of the sixteen line patterns. For each pair it checks the levels and all four flags, so a flag formed from the wrong edge is caught: for example a ring flag that fires on a rising edge, or a flag lost when a line toggles back before the read. It also lines up a pin change with the clearing read on the same edge; a design that lets the clear win drops that change without any sign. All thirty-two control values are written, including loopback. This exposes a swapped remap of the outputs onto the status positions, pins that leak into the loopback value, and a loopback read that clears the flags.

// File: rtl/modem_pkg.sv
// Package: shared widths, bit positions and reset values of the modem
// register block. Assumes the line vector order {carrier, ring, dsr, cts}.
package modem_pkg;
    localparam int NLINES   = 4;
    localparam int IDX_CTS  = 0;
    localparam int IDX_DSR  = 1;
    localparam int IDX_RI   = 2;
    localparam int IDX_DCD  = 3;
    localparam logic [NLINES-1:0] LINE_RST = 4'b1011;

    localparam int CTRL_W   = 5;
    localparam logic [CTRL_W-1:0] CTRL_RST = 5'b01000;

    typedef struct packed {
        logic loop;
        logic aux2;
        logic aux1;
        logic rts;
        logic dtr;
    } ctrl_t;
endpackage

// File: rtl/modem_line_sync.sv
// Module: multi-stage synchroniser for the asynchronous modem inputs.
// Assumes each input is a slow level; no pulse capture is attempted.
module modem_line_sync #(
    parameter int N      = 4,
    parameter int STAGES = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_line
            logic [STAGES-1:0] chain_q;
            // Shift the raw pin level through the stage chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
                else        chain_q <= {chain_q[STAGES-2:0], d_i[g]};
            end
            assign q_o[g] = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/modem_delta_track.sv
// Module: stores the last seen line levels and the sticky change flags.
// The ring flag records only falling edges. A clear request and a new
// change on the same edge leave the new change set.
module modem_delta_track #(
    parameter int N      = 4,
    parameter int RI_IDX = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line_i,
    input  logic         clear_i,
    output logic [N-1:0] state_o,
    output logic [N-1:0] delta_o,
    output logic         any_o
);
    logic [N-1:0] state_q, delta_q, hit;

    // Work out which lines produce a flag this cycle.
    always_comb begin
        hit = state_q ^ line_i;
        hit[RI_IDX] = state_q[RI_IDX] & ~line_i[RI_IDX];
    end

    // Update the stored levels and the sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RST_VAL;
            delta_q <= '0;
        end else begin
            state_q <= line_i;
            delta_q <= (clear_i ? '0 : delta_q) | hit;
        end
    end

    assign state_o = state_q;
    assign delta_o = delta_q;
    assign any_o   = |delta_q;
endmodule

// File: rtl/modem_ctrl_reg.sv
// Module: the control register; keeps only the low CTRL bits of a write.
module modem_ctrl_reg #(
    parameter int W = 5,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] ctrl_o
);
    // Load the register on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     ctrl_o <= RST_VAL;
        else if (wr_en) ctrl_o <= wdata_i;
    end
endmodule

// File: rtl/modem_ctl_status.sv
// Module: top of the modem register block. It decodes the register port,
// drives the output pins and builds the read value, including the
// loopback remap. Assumes one access strobe per cycle.
module modem_ctl_status #(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 8,
    parameter int CTRL_OFS    = 4,
    parameter int STAT_OFS    = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              line_cts,
    input  logic              line_dsr,
    input  logic              line_dcd,
    input  logic              line_ri,
    output logic              out_dtr,
    output logic              out_rts,
    output logic              out_aux1,
    output logic              out_aux2,
    output logic              delta_pending
);
    import modem_pkg::*;

    localparam int NIB = DATA_W / 2;

    logic [NLINES-1:0] line_raw, line_sync, line_state, delta_q;
    logic [CTRL_W-1:0] ctrl_q;
    ctrl_t             ctrl;
    logic              ctrl_sel, stat_sel, stat_clear;
    logic [DATA_W-1:0] unused_wdata;

    assign line_raw = {line_dcd, line_ri, line_dsr, line_cts};
    assign ctrl_sel = (reg_addr == ADDR_W'(CTRL_OFS));
    assign stat_sel = (reg_addr == ADDR_W'(STAT_OFS));
    assign ctrl     = ctrl_t'(ctrl_q);
    assign stat_clear = reg_rd && stat_sel && !ctrl.loop;
    assign unused_wdata = reg_wdata;

    modem_line_sync #(.N(NLINES), .STAGES(SYNC_STAGES), .RST_VAL(LINE_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(line_raw), .q_o(line_sync)
    );

    modem_delta_track #(.N(NLINES), .RI_IDX(IDX_RI), .RST_VAL(LINE_RST)) u_track (
        .clk(clk), .rst_n(rst_n), .line_i(line_sync), .clear_i(stat_clear),
        .state_o(line_state), .delta_o(delta_q), .any_o(delta_pending)
    );

    modem_ctrl_reg #(.W(CTRL_W), .RST_VAL(CTRL_RST)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && ctrl_sel),
        .wdata_i(reg_wdata[CTRL_W-1:0]), .ctrl_o(ctrl_q)
    );

    assign out_dtr  = ctrl.dtr;
    assign out_rts  = ctrl.rts;
    assign out_aux1 = ctrl.aux1;
    assign out_aux2 = ctrl.aux2;

    // Select the read value; in loopback the outputs replace the pins.
    always_comb begin
        reg_rdata = '0;
        if (ctrl_sel) begin
            reg_rdata[CTRL_W-1:0] = ctrl_q;
        end else if (stat_sel) begin
            if (ctrl.loop) begin
                reg_rdata[NIB+IDX_DCD] = ctrl.aux2;
                reg_rdata[NIB+IDX_RI]  = ctrl.aux1;
                reg_rdata[NIB+IDX_DSR] = ctrl.dtr;
                reg_rdata[NIB+IDX_CTS] = ctrl.rts;
            end else begin
                reg_rdata[DATA_W-1:NIB] = line_state;
                reg_rdata[NIB-1:0]      = delta_q;
            end
        end
    end
endmodule

// File: rtl/modem_ctl_status_chk.sv
// Checker: temporal properties of the modem register block, bound to the top.
module modem_ctl_status_chk #(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 8,
    parameter int CTRL_OFS = 4,
    parameter int STAT_OFS = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [4:0]        ctrl_q,
    input logic [3:0]        line_sync,
    input logic [3:0]        line_state,
    input logic [3:0]        delta_q
);
    logic stat_rd, loop_on;
    assign loop_on = ctrl_q[4];
    assign stat_rd = reg_rd && (reg_addr == ADDR_W'(STAT_OFS));

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctrl_q == 5'b01000 && line_state == 4'b1011 && delta_q == 4'b0000));

    p_ctrl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(CTRL_OFS)) |=> (ctrl_q == $past(reg_wdata[4:0])));

    p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (line_state == $past(line_sync)));

    p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_rd && !loop_on) |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

    p_ring_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delta_q[2]) |-> $fell(line_state[2]));

    p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !loop_on && line_sync == line_state) |=> (delta_q == 4'b0000));

    p_loop_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && loop_on && line_sync == line_state) |=> $stable(delta_q));
endmodule

bind modem_ctl_status modem_ctl_status_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .ctrl_q(ctrl_q),
    .line_sync(line_sync), .line_state(line_state), .delta_q(delta_q)
);

// File: tb/tb_modem_ctl_status.sv
module tb_modem_ctl_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       line_cts = 1'b1, line_dsr = 1'b1, line_dcd = 1'b1, line_ri = 1'b0;
    logic       out_dtr, out_rts, out_aux1, out_aux2, delta_pending;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    modem_ctl_status dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .line_cts(line_cts), .line_dsr(line_dsr), .line_dcd(line_dcd),
        .line_ri(line_ri), .out_dtr(out_dtr), .out_rts(out_rts),
        .out_aux1(out_aux1), .out_aux2(out_aux2), .delta_pending(delta_pending)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic set_lines(input logic [3:0] p);
        @(negedge clk);
        {line_dcd, line_ri, line_dsr, line_cts} = p;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic logic [3:0] flags(input logic [3:0] a, input logic [3:0] b);
        logic [3:0] f;
        f = a ^ b;
        f[2] = a[2] & ~b[2];
        return f;
    endfunction

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        chk("R1 pins", {4'b0, out_aux2, out_aux1, out_rts, out_dtr}, 8'h08);
        chk("R1 pending", {7'b0, delta_pending}, 8'h00);
        reg_read(3'd4, rd); chk("R1 ctrl", rd, 8'h08);
        reg_read(3'd6, rd); chk("R1 status", rd, 8'hB0);

        // R2 and R8: every control value, loopback included
        for (int v = 0; v < 32; v++) begin
            reg_write(3'd4, {3'b101, v[4:0]});
            chk("R2 pins", {4'b0, out_aux2, out_aux1, out_rts, out_dtr}, {4'b0, v[3:0]});
            reg_read(3'd4, rd); chk("R2 readback", rd, {3'b0, v[4:0]});
            if (v[4]) begin
                set_lines(v[0] ? 4'b0000 : 4'b1111);
                settle();
                reg_read(3'd6, rd);
                chk("R8 loop remap", rd, {v[3], v[2], v[0], v[1], 4'b0000});
            end
        end
        reg_write(3'd4, 8'h00);
        reg_read(3'd6, rd);

        // R3 R4 R5 R6 R9: all ordered pattern pairs
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                set_lines(a[3:0]); settle();
                reg_read(3'd6, rd);
                set_lines(b[3:0]); settle();
                chk("R9 pending", {7'b0, delta_pending}, {7'b0, |flags(a[3:0], b[3:0])});
                reg_read(3'd6, rd);
                chk("R3 R4 R5 status", rd, {b[3:0], flags(a[3:0], b[3:0])});
                reg_read(3'd6, rd);
                chk("R6 cleared", rd, {b[3:0], 4'b0000});
            end
        end

        // R4 sticky: toggle away and back before reading
        set_lines(4'b0000); settle(); reg_read(3'd6, rd);
        set_lines(4'b1011); settle();
        set_lines(4'b0000); settle();
        reg_read(3'd6, rd); chk("R4 sticky", rd, 8'h0B);

        // R7 change lands on the clearing read edge
        set_lines(4'b0001);
        @(negedge clk);
        @(negedge clk);
        reg_addr = 3'd6; reg_rd = 1'b1;
        #1 chk("R7 pre", reg_rdata, 8'h00);
        @(negedge clk); reg_rd = 1'b0;
        reg_read(3'd6, rd); chk("R7 kept", rd, 8'h11);

        // R8 loop read keeps flags
        set_lines(4'b0000); settle();
        reg_write(3'd4, 8'h10);
        reg_read(3'd6, rd); chk("R8 loop value", rd, 8'h00);
        reg_write(3'd4, 8'h00);
        reg_read(3'd6, rd); chk("R8 flags kept", rd, 8'h01);

        // R10 status write and unused offsets
        set_lines(4'b1010); settle(); reg_read(3'd6, rd);
        reg_write(3'd6, 8'hFF);
        reg_read(3'd6, rd); chk("R10 status write", rd, 8'hA0);
        reg_read(3'd4, rd); chk("R10 ctrl intact", rd, 8'h00);
        for (int o = 0; o < 8; o++) begin
            if (o != 4 && o != 6) begin
                reg_read(o[2:0], rd); chk("R10 other offset", rd, 8'h00);
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule